// File: doc/BRIEF.md
# Shared-Prescaler Input Debounce Filter

This block cleans up to 32 general-purpose input lines before they reach edge and level detection. A single programmable divider turns the bus clock into a sample tick that every line shares. Each line has its own enable bit. An enabled line samples its raw input on every tick. Its filtered level moves only when two back-to-back tick samples agree, so a pulse that is seen by only one tick never gets through. A line whose enable bit is clear passes its raw input straight to the output. Only the interrupt path downstream sees the filtered values.

Software sets the block up through a small write-only port. One word holds the per-line enables and the other holds the divider value. Writing the divider also restarts the tick timer from zero, so the new sample period starts at a known point. The raw inputs are assumed to be synchronous to the clock already; any synchroniser sits upstream.

Top module: `pin_debounce_filter`

## Requirements
- R1: After reset every enable bit is clear, so each output equals its input in the same cycle, and the divider value is 0.
- R2: A write to byte offset 0x40 loads the enable word, where bit i controls line i. A line whose bit is 0 drives its output combinationally from its input.
- R3: A write to byte offset 0x44 loads the divider from bits 23:0 of the write data, and bits 31:24 are ignored. For a divider value P of 2 or more, a sample tick occurs once every P clocks.
- R4: A divider value of 0 or 1 gives a sample tick on every clock.
- R5: A divider write restarts the tick timer. With divider P of 2 or more, the first sample after a write at clock edge W is taken at edge W+P.
- R6: An enabled line updates its output only at a tick edge where the new sample equals the previous tick's sample. A steady change applied just after edge W with P of 0 or 1 shows at the output after edge W+2.
- R7: On an enabled line, a pulse that is captured by only one tick sample never reaches the output.
- R8: While a line is disabled, its filter state follows the raw input. Setting its enable bit therefore leaves the output equal to the current input, with no stale value.
- R9: A write to any other offset changes neither the enable word nor the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Byte offset of the write |
| cfg_wdata | input | 32 | Write data |
| pin_raw | input | NPINS (32) | Raw input lines |
| pin_filt | output | NPINS (32) | Filtered or bypassed lines toward interrupt detection |

## Verification
The bench times output changes to the exact edge for divider values 0, 1, 3 and 5. A divider that is off by one, or a timer that does not restart on a write, moves the update by at least one cycle and misses the check. It also sends a single-cycle pulse and a three-cycle pulse that straddle only one tick; a filter that takes a single sample would let those through. Enabling a line that is already held high catches a filter that kept a stale level while bypassed. Writes with bits set in the upper byte of the divider, and writes to other offsets, catch decoding that is too wide or too loose.

// File: rtl/dbf_pkg.sv
// Package: shared widths and register offsets for the debounce filter.
package dbf_pkg;
    localparam int          CFG_ADDR_W = 8;
    localparam int          CFG_DATA_W = 32;
    localparam int          DIV_W      = 24;
    localparam logic [7:0]  OFS_ENABLE = 8'h40;
    localparam logic [7:0]  OFS_DIV    = 8'h44;
endpackage

// File: rtl/dbf_cfg_regs.sv
// Module: dbf_cfg_regs
// Holds the per-line enable word and the shared divider.
// Assumes writes are single-cycle strobes. A divider write raises
// restart_o in the same cycle, so the tick timer reloads on that edge.
module dbf_cfg_regs #(
    parameter int         NPINS  = 32,
    parameter int         DIV_W  = 24,
    parameter int         ADDR_W = 8,
    parameter int         DATA_W = 32,
    parameter logic [7:0] OFS_EN = 8'h40,
    parameter logic [7:0] OFS_DV = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NPINS-1:0]  en_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              restart_o
);
    logic hit_en;
    logic hit_dv;

    // Decode the two write targets.
    always_comb begin
        hit_en    = wr_i && (addr_i == OFS_EN);
        hit_dv    = wr_i && (addr_i == OFS_DV);
        restart_o = hit_dv;
    end

    // Enable word: cleared by reset, loaded on its own offset only.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_o <= '0;
        else if (hit_en) en_o <= wdata_i[NPINS-1:0];
    end

    // Divider: low DIV_W bits of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_o <= '0;
        else if (hit_dv) div_o <= wdata_i[DIV_W-1:0];
    end

    a_r9_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_en |=> $stable(en_o));
    a_r9_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_dv |=> $stable(div_o));
endmodule

// File: rtl/dbf_tick_gen.sv
// Module: dbf_tick_gen
// Divides the clock by div_i to make a one-clock sample tick shared by all
// lines. Values 0 and 1 give a tick every clock. restart_i reloads the
// count to zero, and the divider register changes only together with it.
module dbf_tick_gen #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // Terminal count: divider minus one, clamped at zero.
    always_comb begin
        limit  = (div_i <= DIV_W'(1)) ? '0 : div_i - DIV_W'(1);
        tick_o = (cnt_q == limit);
    end

    // Count up to the terminal value, then wrap; reload on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) cnt_q <= '0;
        else if (tick_o)         cnt_q <= '0;
        else                     cnt_q <= cnt_q + DIV_W'(1);
    end

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
    a_r3_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o && !restart_i |=> (tick_o == (limit == '0)));
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cnt_q == '0);
endmodule

// File: rtl/dbf_lane.sv
// Module: dbf_lane
// One line's filter. When enabled, it samples on each tick and moves its
// filtered level only when the sample equals the previous tick's sample.
// When disabled, its state follows the raw input and the output bypasses it.
module dbf_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic raw_i,
    output logic out_o
);
    logic samp_q;
    logic filt_q;

    // Sample and filter state; tracks the raw input while bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            filt_q <= 1'b0;
        end else if (!en_i) begin
            samp_q <= raw_i;
            filt_q <= raw_i;
        end else if (tick_i) begin
            samp_q <= raw_i;
            if (raw_i == samp_q) filt_q <= raw_i;
        end
    end

    // Output select: filtered level or raw bypass.
    always_comb out_o = en_i ? filt_q : raw_i;

    a_r6_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i) && !$stable(filt_q) |-> $past(tick_i));
    a_r6_agree: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i && tick_i) && !$stable(filt_q) |-> filt_q == $past(samp_q));
    a_r8_track: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> samp_q == filt_q);
endmodule

// File: rtl/pin_debounce_filter.sv
// Module: pin_debounce_filter (top)
// Debounces NPINS inputs with one shared tick and per-line enables.
// Assumes the raw inputs are already synchronous to clk.
module pin_debounce_filter
    import dbf_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    input  logic [NPINS-1:0]      pin_raw,
    output logic [NPINS-1:0]      pin_filt
);
    logic [NPINS-1:0] en;
    logic [DIV_W-1:0] div;
    logic             restart;
    logic             tick;

    dbf_cfg_regs #(
        .NPINS(NPINS), .DIV_W(DIV_W), .ADDR_W(CFG_ADDR_W), .DATA_W(CFG_DATA_W),
        .OFS_EN(OFS_ENABLE), .OFS_DV(OFS_DIV)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .addr_i(cfg_addr),
        .wdata_i(cfg_wdata), .en_o(en), .div_o(div), .restart_o(restart)
    );

    dbf_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_i(div), .restart_i(restart), .tick_o(tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        dbf_lane u_lane (
            .clk(clk), .rst_n(rst_n), .en_i(en[i]), .tick_i(tick),
            .raw_i(pin_raw[i]), .out_o(pin_filt[i])
        );
    end

    a_r2_bypass_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr && cfg_addr == OFS_ENABLE) |-> en == $past(cfg_wdata[NPINS-1:0]));
endmodule

// File: tb/pin_debounce_filter_tb.sv
module pin_debounce_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] pin_raw = '0;
    logic [31:0] pin_filt;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pin_debounce_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pin_raw(pin_raw), .pin_filt(pin_filt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write ends at the negedge just after the write edge W.
    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic settle_low;
        cfg_write(8'h44, 32'd0);
        pin_raw = '0;
        wait_n(4);
    endtask

    task automatic t_reset;
        pin_raw = 32'hA5A5_0F0F; #1;
        check("R1 reset bypass", pin_filt, 32'hA5A5_0F0F);
        pin_raw = 32'h5A5A_F0F0; #1;
        check("R1 bypass follows", pin_filt, 32'h5A5A_F0F0);
        // Prescale 0 at reset: enable pin0 and time the update.
        pin_raw = '0;
        cfg_write(8'h40, 32'h1);
        wait_n(3);
        pin_raw[0] = 1'b1;
        wait_n(1); check("R1 div zero old", pin_filt & 32'h1, 32'h0);
        wait_n(1); check("R1 div zero new", pin_filt & 32'h1, 32'h1);
    endtask

    task automatic t_tick_every_clock;
        cfg_write(8'h40, 32'h1);
        settle_low();
        pin_raw[0] = 1'b1;
        wait_n(1); check("R6 one tick not enough", pin_filt[0], 1'b0);
        wait_n(1); check("R6 two agreeing ticks", pin_filt[0], 1'b1);
        // Divider 1 behaves the same.
        cfg_write(8'h44, 32'd1);
        pin_raw[0] = 1'b0;
        wait_n(1); check("R4 div one old", pin_filt[0], 1'b1);
        wait_n(1); check("R4 div one new", pin_filt[0], 1'b0);
    endtask

    task automatic t_single_glitch;
        cfg_write(8'h40, 32'h1);
        settle_low();
        pin_raw[0] = 1'b1;
        wait_n(1);
        pin_raw[0] = 1'b0;
        for (int i = 0; i < 6; i++) begin
            check("R7 one-cycle pulse blocked", pin_filt[0], 1'b0);
            wait_n(1);
        end
    endtask

    task automatic t_div5;
        cfg_write(8'h40, 32'h1);
        settle_low();
        cfg_write(8'h44, 32'd5);
        pin_raw[0] = 1'b1;
        wait_n(9); check("R3 div five old at W+9", pin_filt[0], 1'b0);
        wait_n(1); check("R3 div five new at W+10", pin_filt[0], 1'b1);
    endtask

    task automatic t_restart;
        cfg_write(8'h40, 32'h1);
        settle_low();
        cfg_write(8'h44, 32'd5);
        pin_raw[0] = 1'b1;
        wait_n(1);
        cfg_write(8'h44, 32'd5);
        wait_n(9); check("R5 restart old at W+9", pin_filt[0], 1'b0);
        wait_n(1); check("R5 restart new at W+10", pin_filt[0], 1'b1);
    endtask

    task automatic t_wide_glitch;
        cfg_write(8'h40, 32'h1);
        settle_low();
        cfg_write(8'h44, 32'd5);
        wait_n(3);
        pin_raw[0] = 1'b1;
        wait_n(3);
        pin_raw[0] = 1'b0;
        for (int i = 0; i < 12; i++) begin
            check("R7 three-cycle pulse blocked", pin_filt[0], 1'b0);
            wait_n(1);
        end
    endtask

    task automatic t_upper_bits;
        cfg_write(8'h40, 32'h1);
        settle_low();
        cfg_write(8'h44, 32'hAB00_0003);
        pin_raw[0] = 1'b1;
        wait_n(5); check("R3 upper byte ignored old", pin_filt[0], 1'b0);
        wait_n(1); check("R3 upper byte ignored new", pin_filt[0], 1'b1);
    endtask

    task automatic t_mixed_lanes;
        cfg_write(8'h40, 32'h1);
        settle_low();
        pin_raw = 32'h0000_0003; #1;
        check("R2 disabled pin1 direct, pin0 held", pin_filt & 32'h3, 32'h2);
        wait_n(2);
        check("R2 pin0 filtered later", pin_filt & 32'h3, 32'h3);
    endtask

    task automatic t_enable_no_stale;
        cfg_write(8'h40, 32'h0);
        settle_low();
        pin_raw[0] = 1'b1;
        wait_n(3);
        cfg_write(8'h40, 32'h1);
        check("R8 enable keeps live level", pin_filt[0], 1'b1);
    endtask

    task automatic t_other_offsets;
        cfg_write(8'h40, 32'h1);
        settle_low();
        cfg_write(8'h48, 32'hFFFF_FFFE);
        cfg_write(8'h00, 32'h0000_0009);
        pin_raw[0] = 1'b1;
        pin_raw[3] = 1'b1; #1;
        check("R9 enable word unchanged", pin_filt & 32'h9, 32'h8);
        wait_n(1); check("R9 divider unchanged old", pin_filt[0], 1'b0);
        wait_n(1); check("R9 divider unchanged new", pin_filt[0], 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tick_every_clock();
        t_single_glitch();
        t_div5();
        t_restart();
        t_wide_glitch();
        t_upper_bits();
        t_mixed_lanes();
        t_enable_no_stale();
        t_other_offsets();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule